// File: doc/BRIEF.md
# Multi-Event Classification Sequencer

This block steps a power-sourcing port through the alternating class and mark voltage events used to learn how much power an attached device asks for. After a start pulse it selects the class level and then the mark level on the port driver, one event after another. It pulses a sample strobe once the minimum time of each class event has passed, and it records the class code (0 to 4) that the analog front end reports at that strobe. From the recorded codes it forms a requested-power code. It finishes with a one-cycle done pulse, or with a one-cycle abort pulse if the front end flags class current at or above the limit.

The port type (2, 3 or 4) is set at start and fixes how many class events the port may run. It also fixes the length of the first class event and which early exits apply. The exits are taken when particular events return particular codes. Every exit goes straight to the final mark event, so the port voltage never falls to the off level between the first class event and the end of the run. Event lengths and sample points are parameters in clock cycles.

Top module: `class_event_seq`

## Requirements
- R1: `level_o` uses 0 = off, 1 = mark, 2 = class. Out of reset the level is off and all other outputs are zero. A `start_i` pulse while idle makes the level class on the next cycle, and class and mark events then alternate, ending with one final mark event.
- R2: A class event lasts T1_LEN cycles if it is the first event of a type 2 run, and LCF_LEN cycles if it is the first event of a type 3 or 4 run. The second class event lasts C2_LEN cycles and the third to fifth last C3_LEN. Intermediate marks last MK_LEN cycles and the final mark lasts ML_LEN.
- R3: `sample_o` is high for exactly one cycle per class event, in the cycle with zero-based index equal to that event's MIN parameter. `class_code_i` and `over_limit_i` are taken at the rising edge that ends that cycle.
- R4: A run has at most 2 class events for type 2, 4 for type 3 and 5 for type 4. Any `port_type_i` value other than 3 or 4 runs as type 2.
- R5: If the first class event returns a code from 0 to 3, the next event is the final mark, for every type.
- R6: If the first class event returns 4, the run goes to the final mark when `dll_cap_i` is high at the end of that event. Otherwise it continues with a mark event and a second class event.
- R7: For types 3 and 4, if the third class event returns 4, the next event is the final mark.
- R8: For type 4, if the fourth class event returns 1 or 2, the next event is the final mark. Otherwise a mark and a fifth class event follow.
- R9: `over_limit_i` high at a sample edge aborts the run. On the next cycle `abort_o` pulses, the level is off, no done pulse is issued and `pwr_code_o` is unchanged.
- R10: Between start and the done or abort pulse, the level is never off.
- R11: `pwr_code_o` is set when done pulses. If the first two codes are 4 and the third is 1, 2 or 3, it is 3 plus the third code (4, 5 or 6). Otherwise it comes from the first code: 0→2, 1→0, 2→1, 3→2, 4→3.
- R12: `ev_codes_o` holds the code of class event k (k = 0 for the first event) in bits [3k+2:3k]. All fields are cleared at start, and a field of an event that did not run reads 0.
- R13: `done_o` is a one-cycle pulse in the first off cycle after the final mark. A start pulse or a change of `port_type_i` during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run (taken only when idle) |
| port_type_i | input | 3 | Port type 2, 3 or 4, latched at start |
| dll_cap_i | input | 1 | Data-link classification supported |
| class_code_i | input | 3 | Class code from the front end, 0 to 4 |
| over_limit_i | input | 1 | Class current at or above the limit |
| level_o | output | 2 | Port level select: 0 off, 1 mark, 2 class |
| sample_o | output | 1 | Sample strobe within a class event |
| ev_codes_o | output | 15 | Recorded code of each class event |
| pwr_code_o | output | 3 | Resolved requested-power code |
| done_o | output | 1 | Run completed |
| abort_o | output | 1 | Run aborted on over-limit |

## Verification
The bench aims at each early exit on its own: a first code below 4, a first code of 4 with and without data-link support, a third code of 4, and a fourth code of 1 or 2 on a type 4 port. A design that took the wrong exit would give a level trace with too many or too few mark and class events, and often a wrong composite power code. Full-length runs for each type test the event limits, including an unsupported type code. Aborts in the first and in a later class event check that no done pulse and no power-code update leak out. A start pulse and a type change in the middle of a run would restart or reshape a sequencer that fails to ignore them. Seeded random runs mix all of these, and every cycle of the level and strobe trace is compared against the bench's own model.

// File: rtl/cls_seq_pkg.sv
package cls_seq_pkg;
  localparam int NEV    = 5;
  localparam int CODE_W = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_C1, ST_M1, ST_C2, ST_M2, ST_C3, ST_M3, ST_C4, ST_M4, ST_C5, ST_MLAST
  } seq_st_t;

  localparam logic [1:0] LVL_OFF   = 2'd0;
  localparam logic [1:0] LVL_MARK  = 2'd1;
  localparam logic [1:0] LVL_CLASS = 2'd2;

  function automatic logic is_class_st(seq_st_t s);
    return (s == ST_C1) || (s == ST_C2) || (s == ST_C3) || (s == ST_C4) || (s == ST_C5);
  endfunction

  function automatic logic [2:0] class_slot(seq_st_t s);
    case (s)
      ST_C2:   return 3'd1;
      ST_C3:   return 3'd2;
      ST_C4:   return 3'd3;
      ST_C5:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] norm_type(logic [2:0] t);
    return (t == 3'd3 || t == 3'd4) ? t : 3'd2;
  endfunction

  // requested-power code from a single class result
  function automatic logic [2:0] single_pwr(logic [2:0] c);
    case (c)
      3'd1:    return 3'd0;
      3'd2:    return 3'd1;
      3'd4:    return 3'd3;
      default: return 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/cls_evt_timer.sv
module cls_evt_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          in_class,
  input  logic [CW-1:0] ev_len,
  input  logic [CW-1:0] ev_min,
  output logic          smp_hit,
  output logic          end_hit
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign smp_hit = in_class && (cnt_q == ev_min);
  assign end_hit = (cnt_q == ev_len - 1'b1);

  // sample point must fall inside the running event
  assert_sample_in_window_R3: assert property (@(posedge clk) disable iff (rst)
    smp_hit |-> (cnt_q < ev_len));
endmodule

// File: rtl/cls_exit_rules.sv
module cls_exit_rules
  import cls_seq_pkg::*;
(
  input  seq_st_t    cur_st,
  input  logic [2:0] ptype,
  input  logic [2:0] code,
  input  logic       dll_cap,
  output seq_st_t    nxt_st
);
  always_comb begin
    nxt_st = ST_IDLE;
    unique case (cur_st)
      ST_C1:    nxt_st = (code < 3'd4 || dll_cap) ? ST_MLAST : ST_M1;
      ST_M1:    nxt_st = ST_C2;
      ST_C2:    nxt_st = (ptype == 3'd2) ? ST_MLAST : ST_M2;
      ST_M2:    nxt_st = ST_C3;
      ST_C3:    nxt_st = (code == 3'd4) ? ST_MLAST : ST_M3;
      ST_M3:    nxt_st = ST_C4;
      ST_C4:    nxt_st = (ptype == 3'd3 || code == 3'd1 || code == 3'd2) ? ST_MLAST : ST_M4;
      ST_M4:    nxt_st = ST_C5;
      ST_C5:    nxt_st = ST_MLAST;
      default:  nxt_st = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/cls_pwr_resolve.sv
module cls_pwr_resolve
  import cls_seq_pkg::*;
(
  input  logic [2:0] code_a,
  input  logic [2:0] code_b,
  input  logic [2:0] code_c,
  output logic [2:0] pwr
);
  logic triple;
  assign triple = (code_a == 3'd4) && (code_b == 3'd4) && (code_c >= 3'd1) && (code_c <= 3'd3);
  assign pwr    = triple ? (3'd3 + code_c) : single_pwr(code_a);
endmodule

// File: rtl/class_event_seq.sv
module class_event_seq
  import cls_seq_pkg::*;
#(
  parameter int T1_MIN  = 3,
  parameter int T1_LEN  = 12,
  parameter int LCF_MIN = 34,
  parameter int LCF_LEN = 40,
  parameter int C2_MIN  = 3,
  parameter int C2_LEN  = 12,
  parameter int C3_MIN  = 3,
  parameter int C3_LEN  = 8,
  parameter int MK_LEN  = 8,
  parameter int ML_LEN  = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [2:0]            port_type_i,
  input  logic                  dll_cap_i,
  input  logic [CODE_W-1:0]     class_code_i,
  input  logic                  over_limit_i,
  output logic [1:0]            level_o,
  output logic                  sample_o,
  output logic [NEV*CODE_W-1:0] ev_codes_o,
  output logic [2:0]            pwr_code_o,
  output logic                  done_o,
  output logic                  abort_o
);
  localparam int CW = $clog2(T1_LEN + LCF_LEN + C2_LEN + C3_LEN + MK_LEN + ML_LEN + 1);

  seq_st_t            st_q, nxt_ev;
  logic [2:0]         ptype_q;
  logic [CODE_W-1:0]  ev_q [NEV];
  logic               done_q, abort_q;
  logic [2:0]         pwr_q, pwr_calc;
  logic [CW-1:0]      cur_len, cur_min;
  logic               smp_hit, end_hit, in_class;
  logic [2:0]         slot;
  logic [CODE_W-1:0]  cur_code;

  assign in_class = is_class_st(st_q);
  assign slot     = class_slot(st_q);

  always_comb begin
    cur_min = '0;
    unique case (st_q)
      ST_C1:    begin
                  cur_len = (ptype_q >= 3'd3) ? CW'(LCF_LEN) : CW'(T1_LEN);
                  cur_min = (ptype_q >= 3'd3) ? CW'(LCF_MIN) : CW'(T1_MIN);
                end
      ST_C2:    begin cur_len = CW'(C2_LEN); cur_min = CW'(C2_MIN); end
      ST_C3, ST_C4, ST_C5:
                begin cur_len = CW'(C3_LEN); cur_min = CW'(C3_MIN); end
      ST_MLAST: cur_len = CW'(ML_LEN);
      default:  cur_len = CW'(MK_LEN);
    endcase
  end

  cls_evt_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  ((st_q == ST_IDLE) || end_hit),
    .in_class (in_class),
    .ev_len   (cur_len),
    .ev_min   (cur_min),
    .smp_hit  (smp_hit),
    .end_hit  (end_hit)
  );

  assign cur_code = smp_hit ? class_code_i : ev_q[slot];

  cls_exit_rules u_rules (
    .cur_st  (st_q),
    .ptype   (ptype_q),
    .code    (cur_code),
    .dll_cap (dll_cap_i),
    .nxt_st  (nxt_ev)
  );

  cls_pwr_resolve u_resolve (
    .code_a (ev_q[0]),
    .code_b (ev_q[1]),
    .code_c (ev_q[2]),
    .pwr    (pwr_calc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      ptype_q <= 3'd2;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      pwr_q   <= '0;
      for (int i = 0; i < NEV; i++) ev_q[i] <= '0;
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (start_i) begin
          st_q    <= ST_C1;
          ptype_q <= norm_type(port_type_i);
          for (int i = 0; i < NEV; i++) ev_q[i] <= '0;
        end
      end else if (smp_hit && over_limit_i) begin
        st_q    <= ST_IDLE;
        abort_q <= 1'b1;
      end else begin
        if (smp_hit) ev_q[slot] <= class_code_i;
        if (end_hit) begin
          st_q <= nxt_ev;
          if (st_q == ST_MLAST) begin
            done_q <= 1'b1;
            pwr_q  <= pwr_calc;
          end
        end
      end
    end
  end

  always_comb begin
    if (st_q == ST_IDLE)  level_o = LVL_OFF;
    else if (in_class)    level_o = LVL_CLASS;
    else                  level_o = LVL_MARK;
  end

  assign sample_o   = smp_hit;
  assign pwr_code_o = pwr_q;
  assign done_o     = done_q;
  assign abort_o    = abort_q;

  for (genvar g = 0; g < NEV; g++) begin : g_pack
    assign ev_codes_o[g*CODE_W +: CODE_W] = ev_q[g];
  end

  assert_abort_cause_R9: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> $past(sample_o && over_limit_i));
  assert_done_single_R13: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_no_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (level_o == LVL_OFF && $past(level_o) != LVL_OFF) |-> (done_o || abort_o));
  assert_codes_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (level_o == LVL_OFF && !start_i) |=> $stable(ev_codes_o));
  assert_pwr_range_R11: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (pwr_code_o <= 3'd6));
  assert_end_exclusive_R13: assert property (@(posedge clk) disable iff (rst)
    !(done_o && abort_o));
endmodule

// File: tb/class_event_seq_tb.sv
module class_event_seq_tb;
  localparam int T1_MIN = 3,  T1_LEN = 12, LCF_MIN = 34, LCF_LEN = 40;
  localparam int C2_MIN = 3,  C2_LEN = 12, C3_MIN = 3,  C3_LEN = 8;
  localparam int MK_LEN = 8,  ML_LEN = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0, dll_cap_i = 1'b0, over_limit_i = 1'b0;
  logic [2:0] port_type_i = 3'd2, class_code_i = 3'd0;
  logic [1:0] level_o;
  logic sample_o, done_o, abort_o;
  logic [14:0] ev_codes_o;
  logic [2:0] pwr_code_o;

  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  class_event_seq #(
    .T1_MIN(T1_MIN), .T1_LEN(T1_LEN), .LCF_MIN(LCF_MIN), .LCF_LEN(LCF_LEN),
    .C2_MIN(C2_MIN), .C2_LEN(C2_LEN), .C3_MIN(C3_MIN), .C3_LEN(C3_LEN),
    .MK_LEN(MK_LEN), .ML_LEN(ML_LEN)
  ) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .port_type_i(port_type_i),
    .dll_cap_i(dll_cap_i), .class_code_i(class_code_i), .over_limit_i(over_limit_i),
    .level_o(level_o), .sample_o(sample_o), .ev_codes_o(ev_codes_o),
    .pwr_code_o(pwr_code_o), .done_o(done_o), .abort_o(abort_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // expected model
  logic [1:0] e_lvl [256];
  logic       e_smp [256];
  logic [2:0] e_code[256];
  int         e_len;
  logic       e_abort;
  logic [14:0] e_evp;
  logic [2:0] e_pwr = 3'd0;

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] lv, input int len, input int smpat, input logic [2:0] code);
    for (int i = 0; i < len; i++) begin
      e_lvl[e_len] = lv; e_smp[e_len] = (i == smpat); e_code[e_len] = code;
      e_len++;
    end
  endtask

  function automatic logic [2:0] first_map(input logic [2:0] c);
    case (c)
      3'd0: return 3'd2; 3'd1: return 3'd0; 3'd2: return 3'd1;
      3'd3: return 3'd2; default: return 3'd3;
    endcase
  endfunction

  task automatic build(input logic [2:0] ptype, input logic dll, input logic [14:0] codes, input int ovk);
    int pt, len, mn; logic stop, ex; logic [2:0] c;
    logic [2:0] ev [5];
    pt = (ptype == 3 || ptype == 4) ? int'(ptype) : 2;
    e_len = 0; e_abort = 1'b0; stop = 1'b0;
    for (int i = 0; i < 5; i++) ev[i] = 3'd0;
    for (int k = 0; k < 5; k++) begin
      if (!stop) begin
        if (k == 0)      begin len = (pt >= 3) ? LCF_LEN : T1_LEN; mn = (pt >= 3) ? LCF_MIN : T1_MIN; end
        else if (k == 1) begin len = C2_LEN; mn = C2_MIN; end
        else             begin len = C3_LEN; mn = C3_MIN; end
        c = codes[3*k +: 3];
        if (k == ovk) begin
          push(2'd2, mn + 1, mn, c); e_abort = 1'b1; stop = 1'b1;
        end else begin
          push(2'd2, len, mn, c); ev[k] = c;
          ex = (k == 0 && (c < 4 || dll)) || (k == 1 && pt == 2) || (k == 2 && c == 4) ||
               (k == 3 && (pt == 3 || c == 1 || c == 2)) || (k == 4);
          if (ex) begin push(2'd1, ML_LEN, -1, 3'd0); stop = 1'b1; end
          else          push(2'd1, MK_LEN, -1, 3'd0);
        end
      end
    end
    e_evp = {ev[4], ev[3], ev[2], ev[1], ev[0]};
    if (!e_abort)
      e_pwr = (ev[0] == 4 && ev[1] == 4 && ev[2] >= 1 && ev[2] <= 3) ? 3'd3 + ev[2] : first_map(ev[0]);
  endtask

  task automatic run_case(input string tag, input logic [2:0] ptype, input logic dll,
                          input logic [14:0] codes, input int ovk, input int busy_t);
    logic bad; int bt, bl, bel, bs, bes;
    build(ptype, dll, codes, ovk);
    @(negedge clk);
    port_type_i = ptype; dll_cap_i = dll; start_i = 1'b1; class_code_i = 3'd0; over_limit_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0; bad = 1'b0; bt = 0; bl = 0; bel = 0; bs = 0; bes = 0;
    for (int t = 0; t < e_len; t++) begin
      class_code_i = e_code[t];
      over_limit_i = e_abort && (t == e_len - 1);
      start_i      = (t == busy_t);
      if (t == busy_t) port_type_i = (ptype == 3'd4) ? 3'd2 : 3'd4;
      if (!bad && (level_o !== e_lvl[t] || sample_o !== e_smp[t] || done_o || abort_o)) begin
        bad = 1'b1; bt = t; bl = level_o; bel = e_lvl[t]; bs = sample_o; bes = e_smp[t];
      end
      @(negedge clk);
    end
    start_i = 1'b0; over_limit_i = 1'b0;
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s R1 R2 R3 R10 trace cycle %0d: level %0d exp %0d, strobe %0d exp %0d",
               tag, bt, bl, bel, bs, bes);
    end
    check({tag, " R13 R9 end level"}, level_o == 2'd0, level_o, 0);
    check({tag, " R13 done pulse"}, done_o == !e_abort, done_o, !e_abort);
    check({tag, " R9 abort pulse"}, abort_o == e_abort, abort_o, e_abort);
    check({tag, " R11 power code"}, pwr_code_o == e_pwr, pwr_code_o, e_pwr);
    check({tag, " R12 event codes"}, ev_codes_o == e_evp, ev_codes_o, e_evp);
    @(negedge clk);
    check({tag, " R13 single-cycle end"}, !done_o && !abort_o, done_o, 0);
    for (int w = 0; w < 300 && level_o != 2'd0; w++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check("R1 reset level", level_o == 2'd0, level_o, 0);
    check("R1 reset outputs", !sample_o && !done_o && !abort_o && ev_codes_o == 0 && pwr_code_o == 0,
          {sample_o, done_o, abort_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle without start", level_o == 2'd0, level_o, 0);

    // codes packed event 0 in [2:0]
    run_case("R5 type2 first=2",   3'd2, 1'b0, 15'h0002, -1, -1);
    run_case("R5 R2 type3 first=0", 3'd3, 1'b0, 15'h0000, -1, -1);
    run_case("R5 type4 first=3",   3'd4, 1'b1, 15'h0003, -1, -1);
    run_case("R6 type4 first=4 dll", 3'd4, 1'b1, {3'd1,3'd1,3'd1,3'd4,3'd4}, -1, -1);
    run_case("R6 type3 first=4 no dll", 3'd3, 1'b0, {3'd0,3'd0,3'd1,3'd4,3'd4}, -1, -1);
    run_case("R7 type4 third=4",   3'd4, 1'b0, {3'd3,3'd3,3'd4,3'd4,3'd4}, -1, -1);
    run_case("R7 type3 third=4",   3'd3, 1'b0, {3'd3,3'd3,3'd4,3'd4,3'd4}, -1, -1);
    run_case("R8 type4 fourth=1",  3'd4, 1'b0, {3'd3,3'd1,3'd1,3'd4,3'd4}, -1, -1);
    run_case("R8 type4 fourth=2",  3'd4, 1'b0, {3'd3,3'd2,3'd2,3'd4,3'd4}, -1, -1);
    run_case("R4 type4 five events", 3'd4, 1'b0, {3'd2,3'd3,3'd3,3'd4,3'd4}, -1, -1);
    run_case("R4 type3 four events", 3'd3, 1'b0, {3'd3,3'd0,3'd2,3'd4,3'd4}, -1, -1);
    run_case("R4 type2 two events", 3'd2, 1'b0, {3'd3,3'd3,3'd3,3'd0,3'd4}, -1, -1);
    run_case("R4 type code 7",     3'd7, 1'b0, {3'd3,3'd3,3'd3,3'd4,3'd4}, -1, -1);
    run_case("R9 abort third",     3'd4, 1'b0, {3'd1,3'd1,3'd1,3'd4,3'd4}, 2, -1);
    run_case("R9 abort first",     3'd3, 1'b0, 15'h0004, 0, -1);
    run_case("R13 start while busy", 3'd4, 1'b0, {3'd1,3'd1,3'd2,3'd4,3'd4}, -1, 45);
    run_case("R13 start in class", 3'd2, 1'b0, {3'd0,3'd0,3'd0,3'd1,3'd4}, -1, 5);

    for (int n = 0; n < 300; n++) begin
      logic [2:0] pt; logic [14:0] cds; int ov;
      pt = (($urandom % 10) == 0) ? 3'($urandom % 8) : 3'(2 + $urandom % 3);
      for (int k = 0; k < 5; k++)
        cds[3*k +: 3] = (($urandom % 3) != 0) ? 3'd4 : 3'($urandom % 4);
      ov = (($urandom % 6) == 0) ? int'($urandom % 5) : -1;
      run_case("RND", pt, 1'($urandom % 4 == 0), cds, ov, (($urandom % 8) == 0) ? 20 : -1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule